// File: doc/BRIEF.md
# Dual-Bank Wiper Register File

This block is the register file behind a quad digital potentiometer. It holds four 7-bit live wiper codes, four shadow copies of the power-up codes, three general-purpose bytes whose master copies sit in non-volatile storage, and one control byte. A serial slave front end reaches all of it through one byte-wide port that covers nine map addresses. The four channel addresses point at two banks. A mode bit in the control byte selects which bank they reach: the live wiper bank or the power-up shadow bank.

The block drives four wiper codes to the resistor arrays. When shutdown is in force, it also drives a per-channel pair of controls: one opens the high terminal and the other shorts the wiper to the low terminal. Shutdown never changes a stored code, so the arrays go back to the same taps when it ends. A write that must persist (to a shadow register or a general-purpose byte) produces a one-cycle request to an external non-volatile write sequencer. While that sequencer reports busy, the block refuses every write.

Top module: `wiper_regfile`

## Requirements
- R1: After reset every live wiper code and every shadow code is 40h, the general-purpose bytes are 00h, the mode bit is 0, the shutdown-enable bit is 1, and the control byte reads 40h while the busy input is low.
- R2: With the mode bit at 0, an accepted write to address 0 to 3 stores data bits 6:0 in the shadow register of channel 0 to 3 and also in that channel's live wiper code; a read of the same address returns that shadow register.
- R3: With the mode bit at 1, addresses 0 to 3 read and write only the live wiper codes, and the shadow registers keep their values.
- R4: Addresses 4, 5 and 6 each hold a full 8-bit general-purpose byte that reads back as written.
- R5: Writes to address 7 and to addresses 9 to 15 change no register and raise no request; reads of those addresses return 00h.
- R6: The control byte sits at address 8. Bit 7 is the mode bit, bit 6 is the shutdown-enable bit (1 = run), bit 5 reads the busy input, and bits 4:0 read 0. Writes load bits 7 and 6 only.
- R7: While the busy input is 1, every write is refused: no register changes and no request is raised.
- R8: An accepted write to a shadow register or to a general-purpose byte raises the persist request for exactly the next cycle. The request carries the map address and the stored byte, with bit 7 cleared for a shadow write. Writes to live codes or to the control byte raise no request.
- R9: Shutdown is in force unless both the active-low shutdown pin is high and the shutdown-enable bit is 1. While it is in force, all four high-terminal-open and wiper-to-low outputs are 1. Otherwise they are 0. They follow the pin combinationally.
- R10: Read data appears on the cycle after the read is accepted and holds until the next read. Wiper and shadow reads return 0 in bit 7, and data bit 7 is ignored when a wiper or shadow register is written.
- R11: A wiper code changes only after an accepted write to its own channel; entering and leaving shutdown leaves every code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe from the serial slave |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 4 | Map address |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid the cycle after a read |
| nvBusy | input | 1 | Non-volatile write in progress |
| nvWrReq | output | 1 | One-cycle persist request |
| nvWrAddr | output | 4 | Map address of the persist request |
| nvWrData | output | 8 | Byte to persist |
| shutdownPinN | input | 1 | Shutdown pin, low = shutdown |
| wiperCode | output | 28 | Four 7-bit wiper codes, channel 0 in bits 6:0 |
| hiOpen | output | 4 | Per-channel high terminal open |
| wiperToLow | output | 4 | Per-channel wiper shorted to low terminal |

## Verification
The bench goes after the aliasing of addresses 0 to 3. A design that decodes the mode bit the wrong way round would let live-bank writes overwrite the shadows, or would leave a shadow write off the live code. It steps one live code through all 128 values with data bit 7 set, to catch a code that takes the extra bit. It also steps one general-purpose byte through all 256 values. It then tries writes while busy, to expose a lockout that covers only some targets, and walks the four pin and bit combinations of shutdown, where an OR in place of the AND, or a shutdown that clears the codes, shows at once on the outputs.

// File: rtl/wiper_file_pkg.sv
package wiper_file_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    BANK_NONE = 3'd0,
    BANK_LIVE = 3'd1,
    BANK_INIT = 3'd2,
    BANK_GP   = 3'd3,
    BANK_CTL  = 3'd4
  } bank_e;

  typedef struct packed {
    logic             wrStb;
    bank_e            wrBank;
    logic [IDX_W-1:0] wrIdx;
    logic             rdStb;
    bank_e            rdBank;
    logic [IDX_W-1:0] rdIdx;
    logic             nvReq;
  } strobe_t;
endpackage

// File: rtl/wfile_ctrl.sv
module wfile_ctrl
  import wiper_file_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_GP = 3,
  parameter int ADDR_W = 4
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              volMode,
  input  logic              nvBusy,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] GP_BASE  = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] RSV_ADDR = ADDR_W'(NUM_CH + NUM_GP);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH + NUM_GP + 1);

  bank_e            bank;
  logic [IDX_W-1:0] idx;
  logic             wrOk;

  always_comb begin
    bank = BANK_NONE;
    idx  = '0;
    if (accAddr < GP_BASE) begin
      bank = volMode ? BANK_LIVE : BANK_INIT;
      idx  = IDX_W'(accAddr);
    end else if (accAddr < RSV_ADDR) begin
      bank = BANK_GP;
      idx  = IDX_W'(accAddr - GP_BASE);
    end else if (accAddr == CTL_ADDR) begin
      bank = BANK_CTL;
    end
  end

  assign wrOk = accValid && accWrite && !nvBusy && (bank != BANK_NONE);

  always_comb begin
    stb        = '0;
    stb.wrStb  = wrOk;
    stb.wrBank = wrOk ? bank : BANK_NONE;
    stb.wrIdx  = idx;
    stb.rdStb  = accValid && !accWrite;
    stb.rdBank = bank;
    stb.rdIdx  = idx;
    stb.nvReq  = wrOk && (bank == BANK_INIT || bank == BANK_GP);
  end
endmodule

// File: rtl/wfile_datapath.sv
module wfile_datapath
  import wiper_file_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int NUM_GP      = 3,
  parameter int CODE_W      = 7,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int WIPER_RESET = 64,
  parameter int GP_RESET    = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        accAddr,
  input  logic                     nvBusy,
  output logic [NUM_CH*CODE_W-1:0] wiperCode,
  output logic                     volMode,
  output logic                     shdnBit,
  output logic [DATA_W-1:0]        rdData,
  output logic                     nvWrReq,
  output logic [ADDR_W-1:0]        nvWrAddr,
  output logic [DATA_W-1:0]        nvWrData
);
  localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(WIPER_RESET);
  localparam logic [DATA_W-1:0] GP_RST   = DATA_W'(GP_RESET);

  logic [CODE_W-1:0] liveQ [NUM_CH];
  logic [CODE_W-1:0] initQ [NUM_CH];
  logic [DATA_W-1:0] gpQ   [NUM_GP];
  logic              volQ, shdnQ;
  logic [DATA_W-1:0] rdNext;
  logic [CODE_W-1:0] wrCode;

  assign wrCode = wrData[CODE_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic hitLive, hitInit;
    assign hitLive = stb.wrStb && stb.wrBank == BANK_LIVE && stb.wrIdx == IDX_W'(ch);
    assign hitInit = stb.wrStb && stb.wrBank == BANK_INIT && stb.wrIdx == IDX_W'(ch);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ[ch] <= CODE_RST;
        initQ[ch] <= CODE_RST;
      end else begin
        if (hitLive || hitInit) liveQ[ch] <= wrCode;
        if (hitInit) initQ[ch] <= wrCode;
      end
    end

    assign wiperCode[ch*CODE_W +: CODE_W] = liveQ[ch];

    assert_initcopy_R2: assert property (@(posedge clk) disable iff (!rstN)
      $past(hitInit) |-> (liveQ[ch] == initQ[ch]));
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (!rstN) gpQ[g] <= GP_RST;
      else if (stb.wrStb && stb.wrBank == BANK_GP && stb.wrIdx == IDX_W'(g))
        gpQ[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      volQ  <= 1'b0;
      shdnQ <= 1'b1;
    end else if (stb.wrStb && stb.wrBank == BANK_CTL) begin
      volQ  <= wrData[DATA_W-1];
      shdnQ <= wrData[DATA_W-2];
    end
  end

  assign volMode = volQ;
  assign shdnBit = shdnQ;

  always_comb begin
    rdNext = '0;
    unique case (stb.rdBank)
      BANK_LIVE: for (int c = 0; c < NUM_CH; c++)
                   if (stb.rdIdx == IDX_W'(c)) rdNext = DATA_W'(liveQ[c]);
      BANK_INIT: for (int c = 0; c < NUM_CH; c++)
                   if (stb.rdIdx == IDX_W'(c)) rdNext = DATA_W'(initQ[c]);
      BANK_GP:   for (int g = 0; g < NUM_GP; g++)
                   if (stb.rdIdx == IDX_W'(g)) rdNext = gpQ[g];
      BANK_CTL:  rdNext = {volQ, shdnQ, nvBusy, {(DATA_W-3){1'b0}}};
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nvWrReq  <= 1'b0;
      nvWrAddr <= '0;
      nvWrData <= '0;
    end else begin
      nvWrReq <= stb.nvReq;
      if (stb.nvReq) begin
        nvWrAddr <= accAddr;
        nvWrData <= (stb.wrBank == BANK_INIT) ? DATA_W'(wrCode) : wrData;
      end
    end
  end

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    nvBusy |-> !stb.wrStb);

  assert_nvpulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    nvWrReq |-> $past(stb.wrStb && (stb.wrBank == BANK_INIT || stb.wrBank == BANK_GP)));

  assert_rsvzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.rdStb && stb.rdBank == BANK_NONE) |-> (rdData == '0));

  assert_ctlpad_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.rdStb && stb.rdBank == BANK_CTL) |-> (rdData[DATA_W-4:0] == '0));

  assert_codehold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.wrStb) |-> $stable(wiperCode));
endmodule

// File: rtl/wiper_regfile.sv
module wiper_regfile
  import wiper_file_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int NUM_GP      = 3,
  parameter int CODE_W      = 7,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int WIPER_RESET = 64,
  parameter int GP_RESET    = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     accValid,
  input  logic                     accWrite,
  input  logic [ADDR_W-1:0]        accAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic                     nvBusy,
  output logic                     nvWrReq,
  output logic [ADDR_W-1:0]        nvWrAddr,
  output logic [DATA_W-1:0]        nvWrData,
  input  logic                     shutdownPinN,
  output logic [NUM_CH*CODE_W-1:0] wiperCode,
  output logic [NUM_CH-1:0]        hiOpen,
  output logic [NUM_CH-1:0]        wiperToLow
);
  strobe_t stb;
  logic    volMode, shdnBit, sdOn;

  wfile_ctrl #(.NUM_CH(NUM_CH), .NUM_GP(NUM_GP), .ADDR_W(ADDR_W)) u_ctrl (
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .volMode(volMode), .nvBusy(nvBusy), .stb(stb)
  );

  wfile_datapath #(
    .NUM_CH(NUM_CH), .NUM_GP(NUM_GP), .CODE_W(CODE_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .WIPER_RESET(WIPER_RESET), .GP_RESET(GP_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .accAddr(accAddr),
    .nvBusy(nvBusy), .wiperCode(wiperCode), .volMode(volMode), .shdnBit(shdnBit),
    .rdData(rdData), .nvWrReq(nvWrReq), .nvWrAddr(nvWrAddr), .nvWrData(nvWrData)
  );

  assign sdOn       = ~(shutdownPinN & shdnBit);
  assign hiOpen     = {NUM_CH{sdOn}};
  assign wiperToLow = {NUM_CH{sdOn}};

  assert_sdhold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hiOpen[0] && $past(hiOpen[0]) && !$past(accValid && accWrite)) |-> $stable(wiperCode));
endmodule

// File: tb/test_wiper_regfile.sv
`timescale 1ns/1ps
module test_wiper_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0;
  logic [3:0]  accAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        nvBusy = 1'b0;
  logic        nvWrReq;
  logic [3:0]  nvWrAddr;
  logic [7:0]  nvWrData;
  logic        shutdownPinN = 1'b1;
  logic [27:0] wiperCode;
  logic [3:0]  hiOpen, wiperToLow;

  int total = 0, bad = 0;
  logic [6:0] expLive [4];
  logic [6:0] expInit [4];
  logic [7:0] expGp   [3];
  logic       gotReq;
  logic [3:0] gotAddr;
  logic [7:0] gotData;
  logic [7:0] rv;

  always #2 clk = ~clk;

  wiper_regfile i_wiper_regfile (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .wrData(wrData), .rdData(rdData), .nvBusy(nvBusy),
    .nvWrReq(nvWrReq), .nvWrAddr(nvWrAddr), .nvWrData(nvWrData),
    .shutdownPinN(shutdownPinN), .wiperCode(wiperCode), .hiOpen(hiOpen),
    .wiperToLow(wiperToLow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b1; accAddr = a; wrData = d;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    gotReq = nvWrReq; gotAddr = nvWrAddr; gotData = nvWrData;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b0; accAddr = a;
    @(negedge clk);
    accValid = 1'b0;
    d = rdData;
  endtask

  task automatic checkCodes(input string req);
    for (int c = 0; c < 4; c++) check(req, 32'(wiperCode[c*7 +: 7]), 32'(expLive[c]));
  endtask

  task automatic runAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin expLive[c] = 7'h40; expInit[c] = 7'h40; end
    for (int g = 0; g < 3; g++) expGp[g] = 8'h00;

    // R1 reset state
    checkCodes("R1 wiper reset");
    check("R1 no shutdown", 32'(hiOpen), 32'h0);
    check("R1 no nv request", 32'(nvWrReq), 32'h0);
    rd(4'd8, rv); check("R1 ctl reset", 32'(rv), 32'h40);
    for (int g = 0; g < 3; g++) begin rd(4'(4+g), rv); check("R1 gp reset", 32'(rv), 32'h0); end
    rd(4'd2, rv); check("R1 shadow reset", 32'(rv), 32'h40);

    // R2 shadow bank writes with mode 0, plus R8 persist request
    for (int c = 0; c < 4; c++) begin
      logic [7:0] v;
      v = 8'((c * 37 + 5) | 8'h80);
      wr(4'(c), v);
      expInit[c] = v[6:0]; expLive[c] = v[6:0];
      check("R8 shadow req", 32'(gotReq), 32'h1);
      check("R8 shadow addr", 32'(gotAddr), 32'(c));
      check("R8 shadow data", 32'(gotData), 32'(v[6:0]));
      @(negedge clk);
      check("R8 one cycle", 32'(nvWrReq), 32'h0);
    end
    checkCodes("R2 shadow copied to live");
    for (int c = 0; c < 4; c++) begin
      rd(4'(c), rv); check("R2 R10 shadow readback", 32'(rv), 32'(expInit[c]));
    end

    // R3 mode 1, live bank only
    wr(4'd8, 8'hC0);
    check("R8 ctl no req", 32'(gotReq), 32'h0);
    for (int v = 0; v < 128; v++) begin
      wr(4'd0, 8'(v | 8'h80));
      expLive[0] = 7'(v);
      check("R3 R10 live sweep", 32'(wiperCode[6:0]), 32'(v));
      check("R8 live no req", 32'(gotReq), 32'h0);
    end
    for (int c = 1; c < 4; c++) begin
      wr(4'(c), 8'(c * 19 + 2)); expLive[c] = 7'(c * 19 + 2);
    end
    checkCodes("R3 live writes");
    for (int c = 0; c < 4; c++) begin
      rd(4'(c), rv); check("R3 live readback", 32'(rv), 32'(expLive[c]));
    end
    wr(4'd8, 8'h40);
    for (int c = 0; c < 4; c++) begin
      rd(4'(c), rv); check("R3 shadow untouched", 32'(rv), 32'(expInit[c]));
    end
    checkCodes("R11 mode change keeps codes");

    // R4 general-purpose bytes
    for (int v = 0; v < 256; v++) begin
      wr(4'd4, 8'(v)); expGp[0] = 8'(v);
      check("R8 gp req", 32'(gotReq), 32'h1);
      check("R8 gp data", 32'(gotData), 32'(v));
      rd(4'd4, rv); check("R4 gp sweep", 32'(rv), 32'(v));
    end
    wr(4'd5, 8'hA5); expGp[1] = 8'hA5; check("R8 gp addr", 32'(gotAddr), 32'h5);
    wr(4'd6, 8'h3C); expGp[2] = 8'h3C; check("R8 gp addr", 32'(gotAddr), 32'h6);
    for (int g = 0; g < 3; g++) begin rd(4'(4+g), rv); check("R4 gp readback", 32'(rv), 32'(expGp[g])); end

    // R5 reserved and unmapped addresses
    for (int a = 7; a < 16; a++) begin
      if (a == 8) continue;
      wr(4'(a), 8'hFF);
      check("R5 no req", 32'(gotReq), 32'h0);
      rd(4'(a), rv); check("R5 reads zero", 32'(rv), 32'h0);
    end
    checkCodes("R5 codes untouched");
    for (int g = 0; g < 3; g++) begin rd(4'(4+g), rv); check("R5 gp untouched", 32'(rv), 32'(expGp[g])); end
    rd(4'd8, rv); check("R5 ctl untouched", 32'(rv), 32'h40);

    // R6 control layout
    wr(4'd8, 8'h3F);
    rd(4'd8, rv); check("R6 low bits ignored", 32'(rv), 32'h00);
    check("R6 R9 bit shutdown", 32'(hiOpen), 32'hF);
    wr(4'd8, 8'hFF);
    rd(4'd8, rv); check("R6 vol shdn set", 32'(rv), 32'hC0);
    wr(4'd8, 8'h40);

    // R7 busy lockout
    nvBusy = 1'b1;
    rd(4'd8, rv); check("R6 busy bit", 32'(rv), 32'h60);
    wr(4'd1, 8'h11); check("R7 shadow refused req", 32'(gotReq), 32'h0);
    wr(4'd5, 8'h22); check("R7 gp refused req", 32'(gotReq), 32'h0);
    wr(4'd8, 8'h80);
    rd(4'd8, rv); check("R7 ctl refused", 32'(rv), 32'h60);
    rd(4'd1, rv); check("R7 shadow unchanged", 32'(rv), 32'(expInit[1]));
    rd(4'd5, rv); check("R7 gp unchanged", 32'(rv), 32'(expGp[1]));
    checkCodes("R7 codes unchanged");
    nvBusy = 1'b0;
    wr(4'd8, 8'hC0);
    nvBusy = 1'b1;
    wr(4'd2, 8'h05);
    checkCodes("R7 live refused");
    nvBusy = 1'b0;
    wr(4'd8, 8'h40);

    // R9 R11 shutdown truth table
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 2; b++) begin
        wr(4'd8, b ? 8'h40 : 8'h00);
        shutdownPinN = p[0];
        #1;
        check("R9 hiOpen", 32'(hiOpen), (p == 1 && b == 1) ? 32'h0 : 32'hF);
        check("R9 wiperToLow", 32'(wiperToLow), (p == 1 && b == 1) ? 32'h0 : 32'hF);
        repeat (3) @(negedge clk);
        checkCodes("R11 shutdown keeps codes");
      end
    end
    rd(4'd4, rv);
    repeat (5) @(negedge clk);
    check("R10 read data holds", 32'(rdData), 32'(expGp[0]));
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule